// File: doc/BRIEF.md
# Serial Flash Page-Program Command Engine

This block is the device-side receiver and sequencer for the page-program command of a serial flash. It watches a single-bit SPI data line in mode 0. Bits are sampled on the rising clock edge, most significant bit first. The system clock oversamples the line. An 8-bit opcode is decoded first, then a 24-bit address, then any number of data bytes. The data bytes go into a 256-byte page buffer, and a per-byte mask records which offsets were written. The non-volatile array is not modelled. When a program cycle ends, the block raises a one-cycle commit strobe and presents the page index. A read port then exposes the buffer contents and the mask.

A command is accepted only on the rising edge of chip select, and only when four conditions hold. The edge must fall exactly on a byte boundary after at least one complete data byte. The write-enable latch must be set. The target page must lie outside the protected region. No cycle may be in progress. An accepted command starts a self-timed program cycle that lasts a parameterised number of clock cycles. The write-enable latch clears partway through that cycle. External pulses can suspend the cycle and resume it, and the remaining count is frozen while suspended.

The command-frame state machine has five states. F_IDLE moves to F_OPC when chip select falls. F_OPC moves to F_ADDR when the first byte is the program opcode and the engine is idle, and to F_DROP for any other first byte. F_ADDR moves to F_DATA after the third address byte. A rise of chip select returns any state to F_IDLE, and a rise in F_DATA may request a start. The cycle state machine has three states. C_IDLE moves to C_PROG on an accepted start. C_PROG moves to C_IDLE when the count expires, and to C_SUSP on a suspend pulse. C_SUSP moves back to C_PROG on a resume pulse.

Top module: `flashpp_engine`

## Requirements
- R1: The frame is shifted MSB first with spi_mosi sampled on rising spi_sck while spi_cs_n is low. It consists of the opcode 0x02, then address bits 23..0, then data bytes. A frame whose first byte is not 0x02 has no effect: busy stays 0, wel is unchanged and no commit occurs.
- R2: Address bits 23 and 22 are ignored. commit_page equals address bits 21..8, and the first data byte lands at offset equal to address bits 7..0.
- R3: After a commit, rd_mask is 1 exactly at the offsets written by the frame and 0 at every other offset. rd_data at each written offset equals the byte sent.
- R4: When more data bytes arrive than fit before the end of the page, the offset wraps from 255 to 0 within the same page, and a later byte for an offset replaces the earlier one.
- R5: A start is requested only if spi_cs_n rises after a whole number of data bytes, at least one. A rise inside a byte, or a rise after only the opcode and address, discards the frame: busy stays 0 and wel is unchanged.
- R6: wel is set by a wren_pulse while not busy. A program frame arriving while wel is 0 is ignored and busy stays 0.
- R7: An accepted frame raises busy. Busy stays high for exactly TPP_CYCLES clock cycles in which suspended is 0. commit_valid pulses for one cycle right after the last of them, with busy already 0.
- R8: wel is still 1 early in the program cycle. It is cleared when the remaining count reaches half of TPP_CYCLES, so it is 0 whenever commit_valid is 1.
- R9: The protected region depends on bp_level. For 0, nothing is protected. For n from 1 to 7, 2^(n-1) sectors of 64 KiB are protected, clamped to all sectors. With bp_bottom 0 the region is the highest sectors. With bp_bottom 1 it is the lowest sectors. A frame aimed at a protected sector is not executed: busy stays 0 and wel is unchanged.
- R10: suspend_req during C_PROG moves the engine to C_SUSP. There suspended is 1, busy stays 1, the count is frozen and no commit happens. resume_req returns it to C_PROG and the cycle completes normally.
- R11: While busy, including while suspended, a new frame writes nothing into the page buffer and causes no second commit.
- R12: After reset, busy, suspended, wel and commit_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data into the device |
| wren_pulse | input | 1 | Sets the write-enable latch when not busy |
| suspend_req | input | 1 | Pauses a running program cycle |
| resume_req | input | 1 | Continues a paused program cycle |
| bp_level | input | 3 | Size code of the protected region |
| bp_bottom | input | 1 | 1: protected region at the bottom of the array; 0: at the top |
| rd_idx | input | 8 | Page-buffer offset to read |
| busy | output | 1 | Program cycle in progress or suspended |
| suspended | output | 1 | Program cycle is paused |
| wel | output | 1 | Write-enable latch |
| commit_valid | output | 1 | One-cycle strobe when a program cycle completes |
| commit_page | output | ADDR_BITS-8 | Page index of the current or last command |
| rd_data | output | 8 | Buffered byte at rd_idx |
| rd_mask | output | 1 | 1 if the byte at rd_idx was written by the frame |

## Verification
The hardest situation to reach is a second frame arriving during a program cycle. The page buffer must show that this frame was discarded, while the first frame's data is still pending commit. The stimulus starts a long cycle and sends a short frame to a different page before the count expires. The scoreboard then compares the committed buffer against the first frame only. Suspension is driven in the middle of a cycle. The monitor counts unsuspended busy cycles, so a count that drifts while frozen shows up as a wrong cycle length.

// File: rtl/flashpp_pkg.sv
package flashpp_pkg;

    localparam logic [7:0] OPC_PAGE_PROG = 8'h02;
    localparam int         PAGE_BYTES    = 256;

    typedef enum logic [2:0] {
        F_IDLE,
        F_OPC,
        F_ADDR,
        F_DATA,
        F_DROP
    } frame_st_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_PROG,
        C_SUSP
    } cyc_st_t;

endpackage

// File: rtl/flashpp_spi_rx.sv
module flashpp_spi_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       on_boundary
);
    logic [1:0] sck_s, cs_s, mo_s;
    logic       sck_d, cs_d;
    logic [6:0] shreg;
    logic [2:0] bitcnt;
    logic       sck_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= 2'b00;
            cs_s  <= 2'b11;
            mo_s  <= 2'b00;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_s <= {sck_s[0], sck};
            cs_s  <= {cs_s[0], cs_n};
            mo_s  <= {mo_s[0], mosi};
            sck_d <= sck_s[1];
            cs_d  <= cs_s[1];
        end
    end

    assign sck_rise    = sck_s[1] & ~sck_d & ~cs_s[1];
    assign cs_fall     = cs_d & ~cs_s[1];
    assign cs_rise     = ~cs_d & cs_s[1];
    assign on_boundary = (bitcnt == 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (cs_fall) begin
                bitcnt <= '0;
            end else if (sck_rise) begin
                shreg  <= {shreg[5:0], mo_s[1]};
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    byte_val <= {shreg, mo_s[1]};
                end
            end
        end
    end

endmodule

// File: rtl/flashpp_frame.sv
module flashpp_frame
    import flashpp_pkg::*;
#(
    parameter int ADDR_BITS = 22,
    localparam int PW = ADDR_BITS - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_stb,
    input  logic [7:0]    byte_val,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          on_boundary,
    input  logic          busy,
    output logic          wr_stb,
    output logic [7:0]    wr_off,
    output logic [7:0]    wr_data,
    output logic          clr_mask,
    output logic          go_req,
    output logic [PW-1:0] tgt_page
);
    frame_st_t st, st_nx;
    logic [1:0] acnt;
    logic [7:0] off;
    logic       seen;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            F_IDLE: if (cs_fall) st_nx = F_OPC;
            F_OPC: begin
                if (cs_rise)
                    st_nx = F_IDLE;
                else if (byte_stb)
                    st_nx = (byte_val == OPC_PAGE_PROG && !busy) ? F_ADDR : F_DROP;
            end
            F_ADDR: begin
                if (cs_rise)                        st_nx = F_IDLE;
                else if (byte_stb && acnt == 2'd2)  st_nx = F_DATA;
            end
            F_DATA: if (cs_rise) st_nx = F_IDLE;
            F_DROP: if (cs_rise) st_nx = F_IDLE;
            default: st_nx = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb   <= 1'b0;
            wr_off   <= '0;
            wr_data  <= '0;
            clr_mask <= 1'b0;
            go_req   <= 1'b0;
            tgt_page <= '0;
            acnt     <= '0;
            off      <= '0;
            seen     <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            clr_mask <= 1'b0;
            go_req   <= 1'b0;
            unique case (st)
                F_OPC: begin
                    if (!cs_rise && byte_stb && byte_val == OPC_PAGE_PROG && !busy) begin
                        clr_mask <= 1'b1;
                        acnt     <= '0;
                        seen     <= 1'b0;
                    end
                end
                F_ADDR: begin
                    if (!cs_rise && byte_stb) begin
                        acnt <= acnt + 2'd1;
                        if (acnt == 2'd2) off <= byte_val;
                        else              tgt_page <= {tgt_page[PW-9:0], byte_val};
                    end
                end
                F_DATA: begin
                    if (cs_rise) begin
                        go_req <= on_boundary & seen;
                    end else if (byte_stb) begin
                        wr_stb  <= 1'b1;
                        wr_off  <= off;
                        wr_data <= byte_val;
                        off     <= off + 8'd1;
                        seen    <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !busy); // R11

    AST_GO_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        go_req |-> $past(cs_rise && on_boundary)); // R5

endmodule

// File: rtl/flashpp_pagebuf.sv
module flashpp_pagebuf
    import flashpp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_mask,
    input  logic       wr_stb,
    input  logic [7:0] wr_off,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic       rd_mask
);
    logic [7:0] data_all [PAGE_BYTES];
    logic       mask_all [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_cell
        logic [7:0] q;
        logic       m;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
                m <= 1'b0;
            end else if (clr_mask) begin
                m <= 1'b0;
            end else if (wr_stb && wr_off == 8'(i)) begin
                q <= wr_data;
                m <= 1'b1;
            end
        end
        assign data_all[i] = q;
        assign mask_all[i] = m;
    end

    assign rd_data = data_all[rd_idx];
    assign rd_mask = mask_all[rd_idx];

endmodule

// File: rtl/flashpp_cycle.sv
module flashpp_cycle
    import flashpp_pkg::*;
#(
    parameter int TPP_CYCLES = 1000,
    localparam int CW = $clog2(TPP_CYCLES + 1),
    localparam int WEL_CLR = TPP_CYCLES / 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic wren,
    input  logic suspend_req,
    input  logic resume_req,
    output logic busy,
    output logic suspended,
    output logic wel,
    output logic commit_valid
);
    cyc_st_t st, st_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            C_IDLE: if (go) st_nx = C_PROG;
            C_PROG: begin
                if (cnt == CW'(1))    st_nx = C_IDLE;
                else if (suspend_req) st_nx = C_SUSP;
            end
            C_SUSP: if (resume_req) st_nx = C_PROG;
            default: st_nx = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt          <= '0;
            wel          <= 1'b0;
            commit_valid <= 1'b0;
        end else begin
            commit_valid <= 1'b0;
            unique case (st)
                C_IDLE: if (go) cnt <= CW'(TPP_CYCLES);
                C_PROG: begin
                    cnt <= cnt - CW'(1);
                    if (cnt == CW'(1)) commit_valid <= 1'b1;
                end
                default: ;
            endcase
            if (st == C_PROG && cnt == CW'(WEL_CLR))
                wel <= 1'b0;
            else if (wren && st == C_IDLE)
                wel <= 1'b1;
        end
    end

    assign busy      = (st != C_IDLE);
    assign suspended = (st == C_SUSP);

    AST_WEL_LOW_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> !wel); // R8

    AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> $stable(cnt)); // R10

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0 && cnt <= CW'(TPP_CYCLES))); // R7

    AST_COMMIT_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> ($past(busy) && !busy)); // R7

endmodule

// File: rtl/flashpp_engine.sv
module flashpp_engine
    import flashpp_pkg::*;
#(
    parameter int ADDR_BITS  = 22,
    parameter int TPP_CYCLES = 1000,
    localparam int PW = ADDR_BITS - 8,
    localparam int SB = ADDR_BITS - 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_mosi,
    input  logic          wren_pulse,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic [2:0]    bp_level,
    input  logic          bp_bottom,
    input  logic [7:0]    rd_idx,
    output logic          busy,
    output logic          suspended,
    output logic          wel,
    output logic          commit_valid,
    output logic [PW-1:0] commit_page,
    output logic [7:0]    rd_data,
    output logic          rd_mask
);
    logic       byte_stb, cs_fall, cs_rise, on_boundary;
    logic [7:0] byte_val;
    logic       wr_stb, clr_mask, go_req, go, prot_hit;
    logic [7:0] wr_off, wr_data;

    function automatic logic prot_check(input logic [2:0] lvl, input logic bot,
                                        input logic [SB-1:0] sect);
        logic [SB-1:0] shf;
        logic [SB-1:0] ones;
        int k;
        if (lvl == 3'd0) return 1'b0;
        k = int'(lvl) - 1;
        if (k >= SB) return 1'b1;
        shf  = sect >> k;
        ones = {SB{1'b1}} >> k;
        return bot ? (shf == '0) : (shf == ones);
    endfunction

    flashpp_spi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .byte_stb(byte_stb), .byte_val(byte_val), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .on_boundary(on_boundary)
    );

    flashpp_frame #(.ADDR_BITS(ADDR_BITS)) u_frame (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .on_boundary(on_boundary), .busy(busy),
        .wr_stb(wr_stb), .wr_off(wr_off), .wr_data(wr_data), .clr_mask(clr_mask),
        .go_req(go_req), .tgt_page(commit_page)
    );

    flashpp_pagebuf u_buf (
        .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .wr_stb(wr_stb),
        .wr_off(wr_off), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_mask(rd_mask)
    );

    assign prot_hit = prot_check(bp_level, bp_bottom, commit_page[PW-1:PW-SB]);
    assign go       = go_req & wel & ~busy & ~prot_hit;

    flashpp_cycle #(.TPP_CYCLES(TPP_CYCLES)) u_cyc (
        .clk(clk), .rst_n(rst_n), .go(go), .wren(wren_pulse),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .busy(busy), .suspended(suspended), .wel(wel), .commit_valid(commit_valid)
    );

    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R6

    AST_START_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(prot_hit)); // R9

endmodule

// File: tb/test_flashpp_engine.sv
module test_flashpp_engine;
    localparam int TPP = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic wren_pulse = 1'b0, suspend_req = 1'b0, resume_req = 1'b0;
    logic [2:0] bp_level = 3'd0;
    logic bp_bottom = 1'b0;
    logic [7:0] rd_idx = 8'd0;
    logic busy, suspended, wel, commit_valid, rd_mask;
    logic [13:0] commit_page;
    logic [7:0] rd_data;

    int n_chk = 0, n_err = 0;
    int unsigned exp_q[$];
    logic [7:0] tx [0:299];
    logic [7:0] exp_data [0:255];
    logic       exp_mask [0:255];
    int progcnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flashpp_engine #(.ADDR_BITS(22), .TPP_CYCLES(TPP)) i_flashpp_engine (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .wren_pulse(wren_pulse), .suspend_req(suspend_req),
        .resume_req(resume_req), .bp_level(bp_level), .bp_bottom(bp_bottom),
        .rd_idx(rd_idx), .busy(busy), .suspended(suspended), .wel(wel),
        .commit_valid(commit_valid), .commit_page(commit_page),
        .rd_data(rd_data), .rd_mask(rd_mask)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        spi_mosi = b;
        clks(4);
        spi_sck = 1'b1;
        clks(4);
        spi_sck = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] opc, input logic [23:0] a,
                              input int nb, input int extra);
        spi_cs_n = 1'b0;
        clks(4);
        for (int i = 7; i >= 0; i--) spi_bit(opc[i]);
        for (int i = 23; i >= 0; i--) spi_bit(a[i]);
        for (int j = 0; j < nb; j++)
            for (int i = 7; i >= 0; i--) spi_bit(tx[j][i]);
        for (int i = 0; i < extra; i++) spi_bit(1'b1);
        clks(4);
        spi_cs_n = 1'b1;
        clks(8);
    endtask

    task automatic expect_commit(input logic [23:0] a, input int nb);
        for (int j = 0; j < 256; j++) exp_mask[j] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            exp_data[(int'(a[7:0]) + i) % 256] = tx[i];
            exp_mask[(int'(a[7:0]) + i) % 256] = 1'b1;
        end
        exp_q.push_back(int'(a[21:8]));
    endtask

    task automatic pulse_wren();
        wren_pulse = 1'b1;
        clks(1);
        wren_pulse = 1'b0;
        clks(1);
    endtask

    task automatic fill(input int nb, input int seed);
        for (int i = 0; i < nb; i++) tx[i] = 8'((i * 7 + seed) & 255);
    endtask

    task automatic expect_ignored(input string tag);
        clks(100);
        chk(busy == 1'b0, {tag, " busy after ignored frame"}, int'(busy), 0);
        chk(wel == 1'b1, {tag, " wel kept after ignored frame"}, int'(wel), 1);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (busy && !suspended) progcnt++;
            if (commit_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected commit", int'(commit_page), -1);
                end else begin
                    int pg, mism, first;
                    pg = int'(exp_q[0]);
                    mism = 0;
                    first = -1;
                    chk(int'(commit_page) == pg, "R2 commit page", int'(commit_page), pg);
                    chk(progcnt == TPP, "R7 program cycle length", progcnt, TPP);
                    chk(wel == 1'b0, "R8 wel clear at commit", int'(wel), 0);
                    chk(busy == 1'b0, "R7 busy low at commit", int'(busy), 0);
                    for (int i = 0; i < 256; i++) begin
                        rd_idx = 8'(i);
                        #1;
                        if (rd_mask !== exp_mask[i] || (exp_mask[i] && rd_data !== exp_data[i])) begin
                            if (first < 0) first = i;
                            mism++;
                        end
                    end
                    chk(mism == 0, "R3 R4 buffer and mask content (mismatches)", mism, 0);
                    if (first >= 0) begin
                        rd_idx = 8'(first);
                        #1;
                        chk(0, "R3 first mismatching byte", int'(rd_data), int'(exp_data[first]));
                    end
                    void'(exp_q.pop_front());
                end
                progcnt = 0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        clks(10);
        chk(busy == 1'b0 && suspended == 1'b0 && wel == 1'b0 && commit_valid == 1'b0,
            "R12 reset outputs", int'({busy, suspended, wel, commit_valid}), 0);
        rst_n = 1'b1;
        clks(5);
        chk(busy == 1'b0 && wel == 1'b0, "R12 after reset release",
            int'({busy, wel}), 0);

        // R6: no write enable -> ignored
        fill(2, 1);
        send_frame(8'h02, 24'h001234, 2, 0);
        clks(100);
        chk(busy == 1'b0, "R6 ignored without wel", int'(busy), 0);
        pulse_wren();
        chk(wel == 1'b1, "R6 wel set by pulse", int'(wel), 1);

        // R1 R3 R7 R8: basic program
        tx[0] = 8'hA1; tx[1] = 8'hB2; tx[2] = 8'hC3; tx[3] = 8'hD4;
        expect_commit(24'h001234, 4);
        send_frame(8'h02, 24'h001234, 4, 0);
        clks(20);
        chk(busy == 1'b1, "R7 busy raised", int'(busy), 1);
        chk(wel == 1'b1, "R8 wel still set early in cycle", int'(wel), 1);
        wait (exp_q.size() == 0);
        clks(5);

        // R2: top address bits ignored
        pulse_wren();
        fill(3, 5);
        expect_commit(24'hC05678, 3);
        send_frame(8'h02, 24'hC05678, 3, 0);
        wait (exp_q.size() == 0);
        clks(5);

        // R4: wrap, latest wins
        pulse_wren();
        fill(260, 3);
        expect_commit(24'h0002FE, 260);
        send_frame(8'h02, 24'h0002FE, 260, 0);
        wait (exp_q.size() == 0);
        clks(5);

        // R5: misaligned chip-select rise, and no data bytes
        pulse_wren();
        fill(2, 9);
        send_frame(8'h02, 24'h000300, 2, 3);
        expect_ignored("R5 misaligned");
        send_frame(8'h02, 24'h000300, 0, 0);
        expect_ignored("R5 no data");

        // R1: other opcode
        send_frame(8'h03, 24'h000300, 2, 0);
        expect_ignored("R1 other opcode");

        // R9: protection
        bp_level = 3'd1; bp_bottom = 1'b0;
        send_frame(8'h02, 24'h3F0010, 1, 0);
        expect_ignored("R9 top sector protected");
        fill(1, 11);
        expect_commit(24'h3E0010, 1);
        send_frame(8'h02, 24'h3E0010, 1, 0);
        wait (exp_q.size() == 0);
        clks(5);
        pulse_wren();
        bp_level = 3'd2; bp_bottom = 1'b1;
        send_frame(8'h02, 24'h010000, 1, 0);
        expect_ignored("R9 bottom sectors protected");
        expect_commit(24'h020000, 1);
        send_frame(8'h02, 24'h020000, 1, 0);
        wait (exp_q.size() == 0);
        clks(5);
        pulse_wren();
        bp_level = 3'd7; bp_bottom = 1'b0;
        send_frame(8'h02, 24'h000000, 1, 0);
        expect_ignored("R9 whole array protected");
        bp_level = 3'd0;

        // R11: frame while busy is discarded
        fill(2, 21);
        expect_commit(24'h004000, 2);
        send_frame(8'h02, 24'h004000, 2, 0);
        clks(30);
        chk(busy == 1'b1, "R11 cycle running", int'(busy), 1);
        fill(1, 77);
        send_frame(8'h02, 24'h005000, 1, 0);
        wait (exp_q.size() == 0);
        clks(TPP + 200);
        chk(busy == 1'b0, "R11 no second cycle", int'(busy), 0);

        // R10: suspend and resume
        pulse_wren();
        fill(2, 33);
        expect_commit(24'h006000, 2);
        send_frame(8'h02, 24'h006000, 2, 0);
        clks(300);
        suspend_req = 1'b1; clks(1); suspend_req = 1'b0;
        clks(10);
        chk(suspended == 1'b1 && busy == 1'b1, "R10 suspended and busy",
            int'({suspended, busy}), 3);
        clks(1500);
        chk(exp_q.size() == 1 && suspended == 1'b1, "R10 frozen while suspended",
            int'(exp_q.size()), 1);
        resume_req = 1'b1; clks(1); resume_req = 1'b0;
        clks(5);
        chk(suspended == 1'b0 && busy == 1'b1, "R10 resumed", int'({suspended, busy}), 1);
        wait (exp_q.size() == 0);
        clks(10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule